// File: doc/BRIEF.md
# Flash Readout Protection Controller

This block stands between an on-chip flash array and two outside access paths: a parallel programming port and a production-test readout port. At reset it fetches one control byte from the highest flash address, keeps a copy of it, and turns that copy into one of three protection states: off, level one or level two. Each request from the programming port and each strobe from the test port then receives a grant or a deny. A denied request also produces a one-cycle error pulse.

The programming port can run in four access modes. Parallel mode, and the spare idle encoding, are the restricted modes. Any protection level shuts them out completely, and that includes rewriting the control byte. Serial mode and CPU rewrite mode are never restricted. They are the only way to clear protection once it is set. Level two also closes the test readout port.

The control byte uses three 2-bit fields. The level-one request field sits in bits [7:6] and the level-two request field in bits [3:2]. The clear field sits in bits [5:4]. Bits [1:0] are reserved. A granted program or erase that touches the control byte updates the kept copy at once, so the next request sees the new state.

Top module: `flash_guard`

## Requirements
- R1: After reset is released, `fl_rd_o` is high for exactly one cycle, the first one, with `fl_addr_o` all ones. No other flash read follows. `ready_o` rises on the edge that samples `fl_rvalid_i` high, and at that edge the byte on `fl_rdata_i` is kept.
- R2: While `ready_o` is low, every programming-port request and every test strobe is denied with an error pulse, and `level_o` reads 2'b00.
- R3: `level_o` encodes the state as 2'b00 off, 2'b01 level one and 2'b10 level two. Bits [3:2] not equal to 2'b11 give level two. Otherwise, bits [7:6] not equal to 2'b11 give level one. A byte that requests both levels gives level two. Bits [1:0] never affect the result, and 2'b11 never appears.
- R4: A clear field (bits [5:4]) of 2'b00 gives off, whatever the level fields hold.
- R5: In mode 0 (parallel) and mode 3 (idle), while the level is not off, every request is denied. This includes a program of the control byte that would change bits [5:4].
- R6: In mode 1 (serial) and mode 2 (CPU rewrite), every ready request with a legal operation is granted at any level, including a rewrite of the control byte. In modes 0 and 3, requests are granted while the level is off.
- R7: The test readout port is granted when ready and the level is off or level one, and denied at level two.
- R8: Granted operations update the kept byte for the next request:
  - a granted program (op 1) to the all-ones address makes it old AND written data;
  - a granted erase (op 2) whose address has all ones above the low BLK_AW bits restores 0xFF;
  - other addresses leave it unchanged.
- R9: Operation code 3 is always denied. The other codes are 0 read, 1 program and 2 erase.
- R10: A request sampled on a clock edge gets exactly one of grant or deny for the following cycle. A cycle with no request gets neither. `err_o` pulses for one cycle for each deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Access mode: 0 parallel, 1 serial, 2 CPU rewrite, 3 idle |
| req_valid_i | input | 1 | Programming-port request strobe |
| req_op_i | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 reserved |
| req_addr_i | input | AW | Request flash address |
| req_wdata_i | input | 8 | Program data |
| test_rd_i | input | 1 | Test readout port strobe |
| fl_rvalid_i | input | 1 | Flash read data valid |
| fl_rdata_i | input | 8 | Flash read data |
| fl_rd_o | output | 1 | Boot fetch read strobe |
| fl_addr_o | output | AW | Boot fetch address |
| ready_o | output | 1 | Control byte kept, gating active |
| level_o | output | 2 | Protection state |
| req_grant_o | output | 1 | Programming request granted |
| req_deny_o | output | 1 | Programming request denied |
| test_grant_o | output | 1 | Test readout granted |
| test_deny_o | output | 1 | Test readout denied |
| err_o | output | 1 | One-cycle pulse on any deny |

## Verification
The bench boots the block with each of the 256 control byte values. For each one it checks the decoded level and every pairing of mode and operation, which catches a design that ranks level one above level two, ignores the clear field, or decodes the reserved bits. A request placed during the boot fetch catches a design that opens the ports before the byte has arrived. A directed sequence sets protection from parallel mode and then tries to undo it from the same mode, which catches a design that forgets the lock. It then clears protection from CPU rewrite mode and erases the top block before programming a new value. A design that skipped the erase would end up with a cleared byte, not level two, so the wrong level shows on `level_o`.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [1:0] {
        MD_PARALLEL = 2'd0,
        MD_SERIAL   = 2'd1,
        MD_CPU      = 2'd2,
        MD_IDLE     = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_ONE = 2'b01,
        LVL_TWO = 2'b10
    } lvl_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } boot_st_e;

    localparam logic [7:0] CTRL_ERASED = 8'hFF;
    localparam logic [1:0] FIELD_IDLE  = 2'b11;
    localparam logic [1:0] CLEAR_CODE  = 2'b00;

endpackage

// File: rtl/fg_decode.sv
module fg_decode
    import flash_guard_pkg::*;
(
    input  logic [1:0] lvl1_field_i,
    input  logic [1:0] clear_field_i,
    input  logic [1:0] lvl2_field_i,
    output lvl_e       lvl_o
);

    logic want_one;
    logic want_two;
    logic cleared;

    always_comb begin
        want_one = (lvl1_field_i != FIELD_IDLE);
        want_two = (lvl2_field_i != FIELD_IDLE);
        cleared  = (clear_field_i == CLEAR_CODE);
        if (cleared) begin
            lvl_o = LVL_OFF;
        end else if (want_two) begin
            lvl_o = LVL_TWO;
        end else if (want_one) begin
            lvl_o = LVL_ONE;
        end else begin
            lvl_o = LVL_OFF;
        end
    end

endmodule

// File: rtl/fg_boot.sv
module fg_boot
    import flash_guard_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fl_rvalid_i,
    input  logic [7:0]    fl_rdata_i,
    input  logic          upd_en_i,
    input  logic [7:0]    upd_byte_i,
    output logic          fl_rd_o,
    output logic [AW-1:0] fl_addr_o,
    output logic          ready_o,
    output logic [7:0]    ctrl_o
);

    localparam logic [AW-1:0] CTRL_ADDR = {AW{1'b1}};

    boot_st_e st_q;
    boot_st_e st_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_BOOT;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions: BOOT->WAIT always, WAIT->RUN on read data, RUN holds
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_BOOT: st_nxt = ST_WAIT;
            ST_WAIT: st_nxt = fl_rvalid_i ? ST_RUN : ST_WAIT;
            ST_RUN:  st_nxt = ST_RUN;
            default: st_nxt = ST_BOOT;
        endcase
    end

    // outputs per state
    always_comb begin
        fl_addr_o = CTRL_ADDR;
        fl_rd_o   = 1'b0;
        ready_o   = 1'b0;
        unique case (st_q)
            ST_BOOT: fl_rd_o = 1'b1;
            ST_WAIT: fl_rd_o = 1'b0;
            ST_RUN:  ready_o = 1'b1;
            default: fl_rd_o = 1'b0;
        endcase
    end

    // kept copy of the control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= CTRL_ERASED;
        end else if (st_q == ST_WAIT && fl_rvalid_i) begin
            ctrl_o <= fl_rdata_i;
        end else if (upd_en_i) begin
            ctrl_o <= upd_byte_i;
        end
    end

endmodule

// File: rtl/fg_gate.sv
module fg_gate
    import flash_guard_pkg::*;
#(
    parameter int AW     = 20,
    parameter int BLK_AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready_i,
    input  lvl_e          lvl_i,
    input  mode_e         mode_i,
    input  logic          req_valid_i,
    input  op_e           op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    input  logic          test_rd_i,
    input  logic [7:0]    ctrl_i,
    output logic          upd_en_o,
    output logic [7:0]    upd_byte_o,
    output logic          req_grant_o,
    output logic          req_deny_o,
    output logic          test_grant_o,
    output logic          test_deny_o,
    output logic          err_o
);

    localparam int TOP_W = AW - BLK_AW;

    logic restricted;
    logic hits_ctrl;
    logic hits_top;
    logic req_ok;
    logic test_ok;

    always_comb begin
        restricted = (mode_i == MD_PARALLEL) || (mode_i == MD_IDLE);
        hits_ctrl  = (addr_i == {AW{1'b1}});
        hits_top   = (addr_i[AW-1:BLK_AW] == {TOP_W{1'b1}});
        req_ok     = ready_i && (op_i != OP_RSVD) &&
                     (!restricted || lvl_i == LVL_OFF);
        test_ok    = ready_i && (lvl_i != LVL_TWO);
        upd_en_o   = 1'b0;
        upd_byte_o = ctrl_i;
        if (req_valid_i && req_ok) begin
            if (op_i == OP_PROG && hits_ctrl) begin
                upd_en_o   = 1'b1;
                upd_byte_o = ctrl_i & wdata_i;
            end else if (op_i == OP_ERASE && hits_top) begin
                upd_en_o   = 1'b1;
                upd_byte_o = CTRL_ERASED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_grant_o  <= 1'b0;
            req_deny_o   <= 1'b0;
            test_grant_o <= 1'b0;
            test_deny_o  <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            req_grant_o  <= req_valid_i && req_ok;
            req_deny_o   <= req_valid_i && !req_ok;
            test_grant_o <= test_rd_i && test_ok;
            test_deny_o  <= test_rd_i && !test_ok;
            err_o        <= (req_valid_i && !req_ok) || (test_rd_i && !test_ok);
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int AW     = 20,
    parameter int BLK_AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [7:0]    req_wdata_i,
    input  logic          test_rd_i,
    input  logic          fl_rvalid_i,
    input  logic [7:0]    fl_rdata_i,
    output logic          fl_rd_o,
    output logic [AW-1:0] fl_addr_o,
    output logic          ready_o,
    output logic [1:0]    level_o,
    output logic          req_grant_o,
    output logic          req_deny_o,
    output logic          test_grant_o,
    output logic          test_deny_o,
    output logic          err_o
);

    logic       upd_en;
    logic [7:0] upd_byte;
    logic [7:0] ctrl_byte;
    lvl_e       lvl;

    fg_boot #(.AW(AW)) u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .fl_rvalid_i(fl_rvalid_i),
        .fl_rdata_i (fl_rdata_i),
        .upd_en_i   (upd_en),
        .upd_byte_i (upd_byte),
        .fl_rd_o    (fl_rd_o),
        .fl_addr_o  (fl_addr_o),
        .ready_o    (ready_o),
        .ctrl_o     (ctrl_byte)
    );

    fg_decode u_decode (
        .lvl1_field_i (ctrl_byte[7:6]),
        .clear_field_i(ctrl_byte[5:4]),
        .lvl2_field_i (ctrl_byte[3:2]),
        .lvl_o        (lvl)
    );

    fg_gate #(.AW(AW), .BLK_AW(BLK_AW)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready_o),
        .lvl_i       (lvl),
        .mode_i      (mode_e'(mode_i)),
        .req_valid_i (req_valid_i),
        .op_i        (op_e'(req_op_i)),
        .addr_i      (req_addr_i),
        .wdata_i     (req_wdata_i),
        .test_rd_i   (test_rd_i),
        .ctrl_i      (ctrl_byte),
        .upd_en_o    (upd_en),
        .upd_byte_o  (upd_byte),
        .req_grant_o (req_grant_o),
        .req_deny_o  (req_deny_o),
        .test_grant_o(test_grant_o),
        .test_deny_o (test_deny_o),
        .err_o       (err_o)
    );

    assign level_o = ready_o ? lvl : LVL_OFF;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       req_valid_i,
    input logic [1:0] req_op_i,
    input logic       test_rd_i,
    input logic       fl_rd_o,
    input logic       ready_o,
    input logic [1:0] level_o,
    input logic       req_grant_o,
    input logic       req_deny_o,
    input logic       test_grant_o,
    input logic       test_deny_o,
    input logic       err_o
);

    logic restricted;
    assign restricted = (mode_i == 2'd0) || (mode_i == 2'd3);

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_o |=> !fl_rd_o); // R1

    AST_EARLY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && req_valid_i) |=> (req_deny_o && !req_grant_o)); // R2

    AST_EARLY_TEST_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && test_rd_i) |=> (test_deny_o && !test_grant_o)); // R2

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 2'b11); // R3

    AST_PARALLEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ready_o && restricted && level_o != 2'b00) |=> req_deny_o); // R5

    AST_OPEN_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ready_o && !restricted && req_op_i != 2'd3) |=> req_grant_o); // R6

    AST_TEST_LEVEL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (test_rd_i && level_o == 2'b10) |=> test_deny_o); // R7

    AST_TEST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (test_rd_i && ready_o && level_o != 2'b10) |=> test_grant_o); // R7

    AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 2'd3) |=> req_deny_o); // R9

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (req_grant_o != req_deny_o)); // R10

    AST_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid_i && !test_rd_i) |=> !(req_grant_o || req_deny_o || test_grant_o || test_deny_o || err_o)); // R10

endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .test_rd_i   (test_rd_i),
    .fl_rd_o     (fl_rd_o),
    .ready_o     (ready_o),
    .level_o     (level_o),
    .req_grant_o (req_grant_o),
    .req_deny_o  (req_deny_o),
    .test_grant_o(test_grant_o),
    .test_deny_o (test_deny_o),
    .err_o       (err_o)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;

    localparam int AW     = 8;
    localparam int BLK_AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_i;
    logic          req_valid_i;
    logic [1:0]    req_op_i;
    logic [AW-1:0] req_addr_i;
    logic [7:0]    req_wdata_i;
    logic          test_rd_i;
    logic          fl_rvalid_i;
    logic [7:0]    fl_rdata_i;
    logic          fl_rd_o;
    logic [AW-1:0] fl_addr_o;
    logic          ready_o;
    logic [1:0]    level_o;
    logic          req_grant_o;
    logic          req_deny_o;
    logic          test_grant_o;
    logic          test_deny_o;
    logic          err_o;

    always #10 clk = ~clk;

    flash_guard #(.AW(AW), .BLK_AW(BLK_AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_valid_i(req_valid_i),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .test_rd_i(test_rd_i), .fl_rvalid_i(fl_rvalid_i), .fl_rdata_i(fl_rdata_i),
        .fl_rd_o(fl_rd_o), .fl_addr_o(fl_addr_o), .ready_o(ready_o), .level_o(level_o),
        .req_grant_o(req_grant_o), .req_deny_o(req_deny_o), .test_grant_o(test_grant_o),
        .test_deny_o(test_deny_o), .err_o(err_o)
    );

    // flash model: answers a read two edges later
    logic [7:0] flash_byte;
    logic       rd_d1;
    int         rd_count;
    int         addr_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_d1       <= 1'b0;
            fl_rvalid_i <= 1'b0;
        end else begin
            rd_d1       <= fl_rd_o;
            fl_rvalid_i <= rd_d1;
            if (fl_rd_o) begin
                rd_count <= rd_count + 1;
                if (fl_addr_o != {AW{1'b1}}) addr_bad <= addr_bad + 1;
            end
        end
    end
    assign fl_rdata_i = fl_rvalid_i ? flash_byte : 8'h00;

    int total = 0;
    int bad   = 0;
    logic g_q, d_q, tg_q, td_q, e_q;
    logic [1:0] lv_q;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_level(input logic [7:0] b);
        if (b[5:4] == 2'b00) return 2'b00;
        if (b[3:2] != 2'b11) return 2'b10;
        if (b[7:6] != 2'b11) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit exp_grant(input logic [1:0] lv, input logic [1:0] md, input logic [1:0] op);
        if (op == 2'd3) return 1'b0;
        if (md == 2'd0 || md == 2'd3) return (lv == 2'b00);
        return 1'b1;
    endfunction

    task automatic idle_inputs();
        req_valid_i = 1'b0; test_rd_i = 1'b0; mode_i = 2'd0;
        req_op_i = 2'd0; req_addr_i = '0; req_wdata_i = 8'hFF;
    endtask

    task automatic access(input logic [1:0] md, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [7:0] wd, input bit rq, input bit tr);
        @(negedge clk);
        mode_i = md; req_op_i = op; req_addr_i = a; req_wdata_i = wd;
        req_valid_i = rq; test_rd_i = tr;
        @(negedge clk);
        g_q = req_grant_o; d_q = req_deny_o; tg_q = test_grant_o;
        td_q = test_deny_o; e_q = err_o; lv_q = level_o;
        idle_inputs();
    endtask

    task automatic boot(input logic [7:0] b, input bit probe);
        flash_byte = b;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_count = 0; addr_bad = 0;
        rst_n = 1'b1;
        if (probe) begin
            req_valid_i = 1'b1; test_rd_i = 1'b1; req_addr_i = 8'h10;
        end
        @(negedge clk);
        if (probe) begin
            chk(req_deny_o && !req_grant_o && err_o, "R2", {req_grant_o, req_deny_o, err_o}, 3'b011);
            chk(test_deny_o && !test_grant_o, "R2", {test_grant_o, test_deny_o}, 2'b01);
            chk(level_o == 2'b00 && !ready_o, "R2", {ready_o, level_o}, 0);
        end
        idle_inputs();
        @(negedge clk);
        if (probe) chk(!ready_o, "R1", ready_o, 0);
        @(negedge clk);
        chk(ready_o == 1'b1, "R1", ready_o, 1);
        if (probe) begin
            repeat (3) @(negedge clk);
            chk(rd_count == 1 && addr_bad == 0, "R1", rd_count, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        flash_byte = 8'hFF;
        rd_count = 0; addr_bad = 0;
        idle_inputs();
        @(negedge clk);
        chk(!ready_o && !req_grant_o && !req_deny_o && !err_o && level_o == 2'b00,
            "R2", {ready_o, req_grant_o, req_deny_o, err_o}, 0);

        // sweep every control byte value
        for (int b = 0; b < 256; b++) begin
            logic [1:0] el;
            boot(b[7:0], (b % 37) == 0);
            el = exp_level(b[7:0]);
            if (b[5:4] == 2'b00) chk(level_o == el, "R4", level_o, el);
            else                 chk(level_o == el, "R3", level_o, el);
            for (int md = 0; md < 4; md++) begin
                for (int op = 0; op < 4; op++) begin
                    bit eg;
                    eg = exp_grant(el, md[1:0], op[1:0]);
                    access(md[1:0], op[1:0], 8'h10, 8'h00, 1'b1, 1'b0);
                    if (op == 3)
                        chk(g_q == 0 && d_q == 1 && e_q == 1, "R9", {g_q, d_q, e_q}, 3'b011);
                    else if (md == 0 || md == 3)
                        chk(g_q == eg && d_q == !eg && e_q == !eg, "R5", {g_q, d_q, e_q}, {eg, !eg, !eg});
                    else
                        chk(g_q == eg && d_q == !eg && e_q == !eg, "R6", {g_q, d_q, e_q}, {eg, !eg, !eg});
                end
            end
            access(2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 1'b1);
            chk(tg_q == (el != 2'b10) && td_q == (el == 2'b10) && e_q == (el == 2'b10) && !g_q && !d_q,
                "R7", {tg_q, td_q, e_q}, {el != 2'b10, el == 2'b10, el == 2'b10});
        end

        // rewrite sequence on the control byte
        boot(8'hFF, 1'b1);
        access(2'd0, 2'd1, 8'hFF, 8'h3F, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b01, "R8", {g_q, lv_q}, 3'b101);
        access(2'd0, 2'd0, 8'h10, 8'h00, 1'b1, 1'b0);
        chk(d_q && !g_q, "R5", {g_q, d_q}, 2'b01);
        access(2'd0, 2'd1, 8'hFF, 8'hCF, 1'b1, 1'b0);
        chk(d_q && lv_q == 2'b01, "R5", {d_q, lv_q}, 3'b101);
        access(2'd2, 2'd1, 8'hFF, 8'hCF, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b00, "R6", {g_q, lv_q}, 3'b100);
        access(2'd2, 2'd2, 8'hF3, 8'h00, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b00, "R8", {g_q, lv_q}, 3'b100);
        access(2'd1, 2'd1, 8'hFF, 8'hF3, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b10, "R8", {g_q, lv_q}, 3'b110);
        access(2'd1, 2'd0, 8'h10, 8'h00, 1'b0, 1'b1);
        chk(td_q && !tg_q, "R7", {tg_q, td_q}, 2'b01);
        access(2'd1, 2'd2, 8'hE0, 8'h00, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b10, "R8", {g_q, lv_q}, 3'b110);
        access(2'd1, 2'd2, 8'hFF, 8'h00, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b00, "R8", {g_q, lv_q}, 3'b100);
        access(2'd0, 2'd1, 8'h20, 8'h00, 1'b1, 1'b0);
        chk(g_q && lv_q == 2'b00, "R8", {g_q, lv_q}, 3'b100);
        access(2'd0, 2'd0, 8'h10, 8'h00, 1'b0, 1'b0);
        chk(!g_q && !d_q && !tg_q && !td_q && !e_q, "R10", {g_q, d_q, tg_q, td_q, e_q}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule